// File: doc/BRIEF.md
# Chained Descriptor Transmit Engine

This block sends packets that software has queued in memory as a linked chain of descriptors. Each descriptor takes three consecutive 32-bit words at a word-aligned address D. The word at D+0 holds the buffer address. The word at D+4 is the size/status word. The word at D+8 holds the address of the next descriptor. Software writes a start address into the base register, sets the transmit enable in the configuration register, and then writes 1 to the enable bit of the control register. The engine then follows the chain. For each descriptor it fetches the buffer one word at a time, sends the bytes in memory order on a valid/ready byte stream, hands the descriptor back by setting bit 31 of its size word, and moves on to the next descriptor.

A descriptor whose size word already has bit 31 set is still owned by software. It marks the end of the chain: the engine stops, raises an underrun flag and clears its enable bit. When loopback is selected in the configuration register, the packet bytes go to a separate loopback stream that feeds the local receive side, and the normal transmit stream stays quiet.

The memory port is a plain single-request master. Request, address, direction and write data are held until the memory returns a one-cycle acknowledge, and read data arrives with that acknowledge.

Top module: `txd_walker`

## Requirements
- R1: After reset, busy, enable, underrun, packet-sent and the 8-bit sent count are all zero, and mem_req, tx_valid and lb_valid are low.
- R2: A register write with reg_sel=1 (control) and bit 0 set starts a walk only when configuration bit 0 (transmit enable) is 1 and the engine is idle. The first memory access of a walk is a read of base+4. With transmit enable at 0 no memory access happens and busy stays low.
- R3: A write with reg_sel=2 loads the descriptor base register, and bits 1:0 of that register always read as zero.
- R4: When a size word with bit 31 set is read, the walk ends with no bytes sent and no write-back. Underrun is set, the enable bit reads 0, and busy falls in the following cycle.
- R5: The packet length is bits 10:0 of the size word (0 to 2047). Bits 30:11 do not affect the length.
- R6: Bytes of each buffer word leave lowest lane first (bits 7:0 first, little-endian). The last word is trimmed to the length, and the last flag is high on the final byte of a packet only.
- R7: After a packet, the engine writes the size word back to descriptor+4 with bit 31 set and all other bits unchanged. It then increments the sent count, sets packet-sent, and continues with the descriptor that the word at +8 points to.
- R8: While configuration bit 8 (loopback) is 1, packet bytes appear on the lb_* stream and tx_valid stays low. Otherwise they appear on the tx_* stream and lb_valid stays low.
- R9: The loopback selection is captured once per packet, when its descriptor has been read. A change in the middle of a packet takes effect from the next packet.
- R10: Writes to the control register while busy have no effect. In particular, writing 0 does not stop a walk.
- R11: A descriptor with length 0 sends no bytes but is still written back and counted.
- R12: Under back-pressure, a valid byte and its last flag stay steady until accepted. A memory request holds its address and direction until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 config, 1 control, 2 base |
| reg_wdata | input | 32 | Register write data |
| base_o | output | 32 | Descriptor base register |
| dma_en_o | output | 1 | Control enable bit |
| busy_o | output | 1 | Walk in progress |
| underrun_o | output | 1 | Chain ended on an empty descriptor |
| sent_o | output | 1 | At least one packet sent |
| sent_cnt_o | output | 8 | Sent packet count (wraps) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit byte accepted |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of packet |
| lb_valid | output | 1 | Loopback byte valid |
| lb_ready | input | 1 | Loopback byte accepted |
| lb_data | output | 8 | Loopback byte |
| lb_last | output | 1 | Final byte of packet on loopback |

## Verification
A configuration write that flips loopback can arrive while a packet is already streaming, so the register path and the per-packet route choice meet in the same cycle. The bench starts a two-packet chain with loopback off. As soon as the first byte of the first packet is accepted, it turns loopback on. The scoreboard keeps separate queues for the two ports, and it must see all of the first packet on the transmit stream and all of the second on the loopback stream. A control write of 0 in the middle of a walk is also issued, to confirm the walk runs to its empty descriptor.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_BASE = 2'd2;

  localparam int CFG_TX_BIT  = 0;
  localparam int CFG_LB_BIT  = 8;
  localparam int CTRL_EN_BIT = 0;

  localparam int OFS_BUF  = 0;
  localparam int OFS_SIZE = 4;
  localparam int OFS_NEXT = 8;

  typedef enum logic [2:0] {
    W_IDLE, W_SIZE, W_PTR, W_NEXT, W_BUF, W_EMIT, W_BACK
  } walk_e;
endpackage

// File: rtl/txd_regs.sv
module txd_regs
  import txd_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic          busy,
  input  logic          walk_stop,
  input  logic          pkt_done,
  output logic          loop_en,
  output logic          dma_en,
  output logic          start,
  output logic [DW-1:0] base,
  output logic          underrun,
  output logic          sent,
  output logic [CW-1:0] sent_cnt
);
  logic          tx_en_q, tx_en_d, lb_q, lb_d, en_q, en_d;
  logic          und_q, und_d, sent_q, sent_d;
  logic [DW-1:0] base_q, base_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_cfg, wr_ctrl, wr_base;

  assign wr_cfg  = reg_we && (reg_sel == SEL_CFG);
  assign wr_ctrl = reg_we && (reg_sel == SEL_CTRL) && !busy;
  assign wr_base = reg_we && (reg_sel == SEL_BASE);
  assign start   = wr_ctrl && reg_wdata[CTRL_EN_BIT] && tx_en_q;

  always_comb begin
    tx_en_d = tx_en_q;
    lb_d    = lb_q;
    en_d    = en_q;
    base_d  = base_q;
    und_d   = und_q;
    sent_d  = sent_q;
    cnt_d   = cnt_q;
    if (wr_cfg) begin
      tx_en_d = reg_wdata[CFG_TX_BIT];
      lb_d    = reg_wdata[CFG_LB_BIT];
    end
    if (wr_base) base_d = {reg_wdata[DW-1:2], 2'b00};
    if (walk_stop) begin
      en_d  = 1'b0;
      und_d = 1'b1;
    end else if (wr_ctrl) begin
      en_d = reg_wdata[CTRL_EN_BIT];
    end
    if (pkt_done) begin
      sent_d = 1'b1;
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      lb_q    <= 1'b0;
      en_q    <= 1'b0;
      base_q  <= '0;
      und_q   <= 1'b0;
      sent_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      tx_en_q <= tx_en_d;
      lb_q    <= lb_d;
      en_q    <= en_d;
      base_q  <= base_d;
      und_q   <= und_d;
      sent_q  <= sent_d;
      cnt_q   <= cnt_d;
    end
  end

  assign loop_en  = lb_q;
  assign dma_en   = en_q;
  assign base     = base_q;
  assign underrun = und_q;
  assign sent     = sent_q;
  assign sent_cnt = cnt_q;

  AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    walk_stop |=> (!en_q && und_q)); // R4
  AST_BUSY_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !walk_stop && $past(busy)) |=> $stable(en_q)); // R10
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[1:0] == 2'b00); // R3
endmodule

// File: rtl/txd_emit.sv
module txd_emit #(
  parameter int DW = 32,
  localparam int BYTES = DW / 8,
  localparam int CW = $clog2(BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] word,
  input  logic [CW-1:0] nbytes,
  input  logic          final_in,
  output logic          valid,
  output logic [7:0]    data,
  output logic          last,
  input  logic          ready,
  output logic          idle
);
  logic [DW-1:0] sh_q, sh_d;
  logic [CW-1:0] left_q, left_d;
  logic          fin_q, fin_d;

  assign valid = (left_q != '0);
  assign idle  = !valid;
  assign data  = sh_q[7:0];
  assign last  = fin_q && (left_q == CW'(1));

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    fin_d  = fin_q;
    if (load) begin
      sh_d   = word;
      left_d = nbytes;
      fin_d  = final_in;
    end else if (valid && ready) begin
      sh_d   = sh_q >> 8;
      left_d = left_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      fin_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      fin_q  <= fin_d;
    end
  end

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data) && $stable(last))); // R12
  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> idle); // R12
endmodule

// File: rtl/txd_route.sv
module txd_route (
  input  logic       sel_lb,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic       s_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_last,
  input  logic       tx_ready,
  output logic       lb_valid,
  output logic [7:0] lb_data,
  output logic       lb_last,
  input  logic       lb_ready
);
  assign tx_valid = s_valid && !sel_lb;
  assign lb_valid = s_valid && sel_lb;
  assign tx_data  = s_data;
  assign lb_data  = s_data;
  assign tx_last  = s_last && !sel_lb;
  assign lb_last  = s_last && sel_lb;
  assign s_ready  = sel_lb ? lb_ready : tx_ready;
endmodule

// File: rtl/txd_seq.sv
module txd_seq
  import txd_pkg::*;
#(
  parameter int DW = 32,
  parameter int LEN_W = 11,
  localparam int BYTES = DW / 8,
  localparam int CW = $clog2(BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] base,
  input  logic          loop_en,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          emit_load,
  output logic [DW-1:0] emit_word,
  output logic [CW-1:0] emit_nbytes,
  output logic          emit_final,
  input  logic          emit_idle,
  output logic          pkt_done,
  output logic          walk_stop,
  output logic          loop_sel
);
  localparam logic [DW-1:0] EMPTY_MASK = DW'(1) << (DW - 1);
  localparam logic [DW-1:0] ALIGN_MASK = ~DW'(3);

  walk_e             st_q, st_d;
  logic [DW-1:0]     cur_q, cur_d, buf_q, buf_d, size_q, size_d, next_q, next_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              lsel_q, lsel_d;
  logic [CW-1:0]     nb;

  assign nb          = (left_q >= LEN_W'(BYTES)) ? CW'(BYTES) : left_q[CW-1:0];
  assign emit_word   = mem_rdata;
  assign emit_nbytes = nb;
  assign emit_final  = (left_q <= LEN_W'(BYTES));
  assign busy        = (st_q != W_IDLE);
  assign loop_sel    = lsel_q;

  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    buf_d     = buf_q;
    size_d    = size_q;
    next_d    = next_q;
    left_d    = left_q;
    lsel_d    = lsel_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = size_q | EMPTY_MASK;
    emit_load = 1'b0;
    pkt_done  = 1'b0;
    walk_stop = 1'b0;
    case (st_q)
      W_IDLE: begin
        if (start) begin
          cur_d = base;
          st_d  = W_SIZE;
        end
      end
      W_SIZE: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + DW'(OFS_SIZE);
        if (mem_ack) begin
          if (mem_rdata[DW-1]) begin
            walk_stop = 1'b1;
            st_d      = W_IDLE;
          end else begin
            size_d = mem_rdata;
            left_d = mem_rdata[LEN_W-1:0];
            st_d   = W_PTR;
          end
        end
      end
      W_PTR: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + DW'(OFS_BUF);
        if (mem_ack) begin
          buf_d = mem_rdata & ALIGN_MASK;
          st_d  = W_NEXT;
        end
      end
      W_NEXT: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + DW'(OFS_NEXT);
        if (mem_ack) begin
          next_d = mem_rdata & ALIGN_MASK;
          lsel_d = loop_en;
          st_d   = (left_q == '0) ? W_BACK : W_BUF;
        end
      end
      W_BUF: begin
        mem_req  = 1'b1;
        mem_addr = buf_q;
        if (mem_ack) begin
          emit_load = 1'b1;
          left_d    = left_q - LEN_W'(nb);
          buf_d     = buf_q + DW'(BYTES);
          st_d      = W_EMIT;
        end
      end
      W_EMIT: begin
        if (emit_idle) st_d = (left_q == '0) ? W_BACK : W_BUF;
      end
      W_BACK: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = cur_q + DW'(OFS_SIZE);
        if (mem_ack) begin
          pkt_done = 1'b1;
          cur_d    = next_q;
          st_d     = W_SIZE;
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      cur_q  <= '0;
      buf_q  <= '0;
      size_q <= '0;
      next_q <= '0;
      left_q <= '0;
      lsel_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      buf_q  <= buf_d;
      size_q <= size_d;
      next_q <= next_d;
      left_q <= left_d;
      lsel_q <= lsel_d;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_stop |=> !busy); // R4
  AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mem_req && !mem_we && mem_addr == $past(base) + DW'(OFS_SIZE))); // R2
  AST_BACK_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[DW-1]); // R7
endmodule

// File: rtl/txd_walker.sv
module txd_walker
  import txd_pkg::*;
#(
  parameter int DW = 32,
  parameter int LEN_W = 11,
  parameter int CNT_W = 8,
  localparam int CW = $clog2(DW / 8 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] base_o,
  output logic          dma_en_o,
  output logic          busy_o,
  output logic          underrun_o,
  output logic          sent_o,
  output logic [CNT_W-1:0] sent_cnt_o,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          lb_valid,
  input  logic          lb_ready,
  output logic [7:0]    lb_data,
  output logic          lb_last
);
  logic          start, loop_en, busy, walk_stop, pkt_done, loop_sel;
  logic          e_load, e_final, e_idle, s_valid, s_last, s_ready;
  logic [DW-1:0] base, e_word;
  logic [CW-1:0] e_nb;
  logic [7:0]    s_data;

  txd_regs #(.DW(DW), .CW(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .busy(busy), .walk_stop(walk_stop),
    .pkt_done(pkt_done), .loop_en(loop_en), .dma_en(dma_en_o),
    .start(start), .base(base), .underrun(underrun_o), .sent(sent_o),
    .sent_cnt(sent_cnt_o)
  );

  txd_seq #(.DW(DW), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .loop_en(loop_en),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .emit_load(e_load), .emit_word(e_word), .emit_nbytes(e_nb),
    .emit_final(e_final), .emit_idle(e_idle), .pkt_done(pkt_done),
    .walk_stop(walk_stop), .loop_sel(loop_sel)
  );

  txd_emit #(.DW(DW)) u_emit (
    .clk(clk), .rst_n(rst_n), .load(e_load), .word(e_word), .nbytes(e_nb),
    .final_in(e_final), .valid(s_valid), .data(s_data), .last(s_last),
    .ready(s_ready), .idle(e_idle)
  );

  txd_route u_route (
    .sel_lb(loop_sel), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready), .lb_valid(lb_valid),
    .lb_data(lb_data), .lb_last(lb_last), .lb_ready(lb_ready)
  );

  assign base_o = base;
  assign busy_o = busy;

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && lb_valid)); // R8
  AST_ROUTE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> $stable(loop_sel)); // R9
endmodule

// File: tb/sim_txd_walker.sv
module sim_txd_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] base_o;
  logic        dma_en_o, busy_o, underrun_o, sent_o;
  logic [7:0]  sent_cnt_o;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, tx_last, lb_valid, lb_ready, lb_last;
  logic [7:0]  tx_data, lb_data;

  always #10 clk = ~clk;

  txd_walker u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .base_o(base_o), .dma_en_o(dma_en_o),
    .busy_o(busy_o), .underrun_o(underrun_o), .sent_o(sent_o),
    .sent_cnt_o(sent_cnt_o), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .lb_valid(lb_valid),
    .lb_ready(lb_ready), .lb_data(lb_data), .lb_last(lb_last)
  );

  int checks = 0;
  int errors = 0;
  int acks = 0;
  int wr_acks = 0;
  int tx_hs = 0;
  int cyc = 0;
  bit finished = 0;
  bit arm = 0;
  logic [31:0] first_addr;
  logic [31:0] mem [0:255];
  logic [8:0]  exp_tx[$];
  logic [8:0]  exp_lb[$];
  logic [7:0]  rdy_ctr;

  // memory model: one-cycle acknowledge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:2]];
      end
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_ctr <= '0;
    else        rdy_ctr <= rdy_ctr + 8'd1;
  end
  assign tx_ready = (rdy_ctr % 3) != 2;
  assign lb_ready = (rdy_ctr % 4) != 1;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (arm && mem_req) begin
        first_addr = mem_addr;
        arm = 0;
      end
      if (mem_ack) begin
        acks++;
        if (mem_we) wr_acks++;
      end
      if (tx_valid && tx_ready) begin
        tx_hs++;
        checks++;
        if (exp_tx.size() == 0) begin
          errors++;
          $display("FAIL R8 tx byte got %0h expected none", {tx_last, tx_data});
        end else begin
          logic [8:0] e;
          e = exp_tx.pop_front();
          if ({tx_last, tx_data} !== e) begin
            errors++;
            $display("FAIL R6 tx byte got %0h expected %0h", {tx_last, tx_data}, e);
          end
        end
      end
      if (lb_valid && lb_ready) begin
        checks++;
        if (exp_lb.size() == 0) begin
          errors++;
          $display("FAIL R8 lb byte got %0h expected none", {lb_last, lb_data});
        end else begin
          logic [8:0] e;
          e = exp_lb.pop_front();
          if ({lb_last, lb_data} !== e) begin
            errors++;
            $display("FAIL R9 lb byte got %0h expected %0h", {lb_last, lb_data}, e);
          end
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got busy %0d expected idle", busy_o);
      summary();
    end
  end

  task automatic reg_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic make_desc(input int d, input logic [31:0] b, input logic [31:0] sz,
                           input logic [31:0] nx);
    mem[d >> 2]       = b;
    mem[(d >> 2) + 1] = sz;
    mem[(d >> 2) + 2] = nx;
  endtask

  // driver: fill a buffer and queue the expected bytes on one port
  task automatic load_pkt(input int b, input int len, input int seed, input bit to_lb);
    for (int i = 0; i < len; i++) begin
      logic [7:0] v;
      logic [31:0] w;
      v = 8'(seed + i * 7);
      w = mem[(b + i) >> 2];
      w[8 * ((b + i) % 4) +: 8] = v;
      mem[(b + i) >> 2] = w;
      if (to_lb) exp_lb.push_back({(i == len - 1), v});
      else       exp_tx.push_back({(i == len - 1), v});
    end
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    reg_we = 0; reg_sel = 0; reg_wdata = 0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", busy_o, 0);
    check("R1 en", dma_en_o, 0);
    check("R1 flags", {underrun_o, sent_o}, 0);
    check("R1 count", sent_cnt_o, 0);
    check("R1 outputs", {mem_req, tx_valid, lb_valid}, 0);

    // R3 base alignment
    reg_wr(2'd2, 32'h0000_0103);
    check("R3 base low bits", base_o, 32'h100);

    // R2 no start without transmit enable
    reg_wr(2'd1, 32'h1);
    repeat (10) @(negedge clk);
    check("R2 no busy without tx enable", busy_o, 0);
    check("R2 no memory access", acks, 0);

    // chain A(len 6, junk bits) -> B(len 0) -> C(empty)
    make_desc(32'h100, 32'h200, 32'h0000_F806, 32'h110);
    make_desc(32'h110, 32'h240, 32'h0000_0000, 32'h120);
    make_desc(32'h120, 32'h0,   32'h8000_0000, 32'h0);
    load_pkt(32'h200, 6, 8'h31, 0);
    reg_wr(2'd0, 32'h1);
    arm = 1;
    reg_wr(2'd1, 32'h1);
    check("R2 busy after start", busy_o, 1);
    reg_wr(2'd1, 32'h0);
    check("R10 write ignored while busy", {busy_o, dma_en_o}, 2'b11);
    wait_idle();
    check("R2 first read address", first_addr, 32'h104);
    check("R5 R7 write back A", mem[32'h104 >> 2], 32'h8000_F806);
    check("R11 write back B", mem[32'h114 >> 2], 32'h8000_0000);
    check("R7 R11 count", sent_cnt_o, 2);
    check("R7 sent flag", sent_o, 1);
    check("R4 underrun and enable", {underrun_o, dma_en_o, busy_o}, 3'b100);
    check("R4 only two write backs", wr_acks, 2);
    check("R6 all tx bytes seen", exp_tx.size(), 0);

    // R8 loopback packet D(len 9) -> C(empty)
    make_desc(32'h130, 32'h280, 32'h0000_0009, 32'h120);
    load_pkt(32'h280, 9, 8'h90, 1);
    reg_wr(2'd0, 32'h101);
    reg_wr(2'd2, 32'h130);
    reg_wr(2'd1, 32'h1);
    wait_idle();
    check("R8 all lb bytes seen", exp_lb.size(), 0);
    check("R7 count after loopback", sent_cnt_o, 3);

    // R9 loopback change mid-packet: E(len 8) on tx, F(len 3) on lb
    make_desc(32'h150, 32'h300, 32'h0000_0008, 32'h160);
    make_desc(32'h160, 32'h340, 32'h0000_0003, 32'h120);
    load_pkt(32'h300, 8, 8'h11, 0);
    load_pkt(32'h340, 3, 8'hC0, 1);
    reg_wr(2'd0, 32'h1);
    reg_wr(2'd2, 32'h150);
    begin
      int hs0;
      hs0 = tx_hs;
      reg_wr(2'd1, 32'h1);
      while (tx_hs == hs0) @(negedge clk);
    end
    reg_wr(2'd0, 32'h101);
    wait_idle();
    check("R9 tx packet complete", exp_tx.size(), 0);
    check("R9 lb packet complete", exp_lb.size(), 0);
    check("R7 final count", sent_cnt_o, 5);
    check("R7 write back F", mem[32'h164 >> 2], 32'h8000_0003);

    summary();
  end
endmodule